// File: doc/BRIEF.md
# Serial Flash Shift Engine

This block is the bit-level core of a single-lane SPI master for serial flash. Software pushes 32-bit words into a transmit queue through a write port that carries a size select: full word, or a partial word of one, two or three bytes. The engine takes one entry at a time and drives it out on `mosi`. Each byte goes most significant bit first, and the byte in bits [7:0] leaves first. One bit is captured from `miso` for every bit sent. The captured bytes are packed into a 32-bit word and pushed into a receive queue. For a partial entry the received bytes sit in the upper lanes of that word.

A single configuration word sets the enable, clock polarity and phase, and a power-of-two serial clock divisor. It also holds an active-low select field, a manual chip-select override and a manual-start gate. With manual start off, the engine drains the transmit queue whenever it is enabled and has room to receive. With manual start on, it waits for a start pulse and then drains until the queue is empty.

Top module: `sflash_shift_engine`

## Requirements
- R1: After reset `sclk` is 0, every `ss_n` bit is 1, `busy` is 0, `tx_empty` is 1 and `rx_valid` is 0.
- R2: The divisor field is configuration bits [5:3], value d in 0..7. One serial bit lasts 2<<d reference clocks, so consecutive capture edges within a byte are 2<<d cycles apart.
- R3: Configuration bit 1 sets the idle level of `sclk`. Configuration bit 2 chooses the capture edge: the leading edge (idle to active) when 0, the trailing edge when 1. `mosi` holds steady across every capture edge.
- R4: Within an entry, the byte in data bits [8k+7:8k] is sent as the k-th byte, and each byte is sent most significant bit first.
- R5: `tx_sel` = 1, 2 or 3 sends only the low 1, 2 or 3 bytes of `tx_data`. `tx_sel` = 0 sends all four bytes.
- R6: For an entry of N bytes, the k-th received byte lands in byte lane 4-N+k of the receive word, and all unused lanes read 0. A full word therefore fills lane k with the k-th byte.
- R7: A partial write is accepted only while the transmit queue is empty. A full-word write is dropped while a partial entry is still queued. A dropped write sends nothing and produces no receive word.
- R8: With configuration bit 0 set and bit 15 clear, a transfer starts whenever the transmit queue holds an entry. With bit 0 clear, nothing starts.
- R9: With bit 15 set, no entry starts until a configuration write carries bit 16 set. The engine then runs until the transmit queue is empty and afterwards waits for a new start pulse.
- R10: The select field begins at configuration bit 10 and is active low. With bit 14 set, `ss_n` follows the field at all times. With bit 14 clear, `ss_n` shows the field only while an entry shifts and is all ones otherwise.
- R11: Each queue holds 63 entries. `tx_full` rises at 63, and further writes are dropped. No entry starts while the receive queue is full.
- R12: Each transmitted entry yields exactly one receive word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 17 | Configuration value; bit 16 is the start pulse |
| cfg_rdata | output | 17 | Stored configuration, bit 16 reads 0 |
| tx_we | input | 1 | Transmit write strobe |
| tx_sel | input | 2 | 0 full word, 1..3 partial byte count |
| tx_data | input | 32 | Transmit data |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_re | input | 1 | Receive pop strobe |
| rx_data | output | 32 | Head of receive queue |
| rx_valid | output | 1 | Receive queue not empty |
| busy | output | 1 | An entry is shifting |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NCS | Active-low selects |

## Verification
A wrong bit counter or lane pointer corrupts the first byte stream that follows. It shows up as a byte mismatch on `mosi` within eight capture edges, or as a misplaced lane in the next receive word. A stuck divisor or half-period counter changes the spacing of capture edges on the second bit of the next byte. A broken arm flag or partial marker shows as an entry that starts before its start pulse, or as an extra byte after a write that should have been dropped. Both are visible within tens of cycles of the offending write.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

  localparam int DIV_W = 3;

  // byte count carried by a transmit size select
  function automatic logic [2:0] nbytes_of(input logic [1:0] sel);
    return (sel == 2'd0) ? 3'd4 : {1'b0, sel};
  endfunction

  // reference clocks per serial half period
  function automatic logic [7:0] half_len(input logic [DIV_W-1:0] div);
    return 8'd1 << div;
  endfunction

  // reorder lanes so the byte of lane 0 sits at the top of the shift register
  function automatic logic [31:0] stream_of(input logic [31:0] d);
    logic [31:0] s;
    for (int k = 0; k < 4; k++) s[8*(3-k) +: 8] = d[8*k +: 8];
    return s;
  endfunction

  // move n captured bytes into the upper n lanes, first byte lowest
  function automatic logic [31:0] place_rx(input logic [31:0] r, input logic [2:0] n);
    logic [31:0] o;
    o = '0;
    for (int k = 0; k < 4; k++)
      if (k < int'(n)) o[8*(4-int'(n)+k) +: 8] = r[8*(int'(n)-1-k) +: 8];
    return o;
  endfunction

endpackage

// File: rtl/sfe_fifo.sv
module sfe_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 63
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign dout  = mem[rd_q];

  always_ff @(posedge clk) if (push) mem[wr_q] <= din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= bump(wr_q);
      if (pop)  rd_q <= bump(rd_q);
      if (push && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  a_r11_no_underflow: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);

endmodule

// File: rtl/sfe_shifter.sv
module sfe_shifter
  import sfe_pkg::*;
#(
  parameter int HC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             rx_full,
  input  logic [31:0]      tx_word,
  input  logic [2:0]       tx_nb,
  input  logic [DIV_W-1:0] div,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             miso,
  output logic             start_ev,
  output logic             word_done,
  output logic [31:0]      rx_word,
  output logic             busy,
  output logic             sclk,
  output logic             mosi
);
  logic            busy_q, phase_q;
  logic [HC_W-1:0] hc_q;
  logic [31:0]     sh_q, rx_q;
  logic [5:0]      bits_q;
  logic [2:0]      nb_q;

  logic half_end, bit_end;
  assign half_end  = busy_q && (hc_q == HC_W'(half_len(div) - 8'd1));
  assign bit_end   = half_end && phase_q;
  assign word_done = bit_end && (bits_q == 6'd1);
  assign start_ev  = !busy_q && go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      hc_q    <= '0;
      sh_q    <= '0;
      rx_q    <= '0;
      bits_q  <= '0;
      nb_q    <= '0;
    end else if (start_ev) begin
      busy_q  <= 1'b1;
      phase_q <= 1'b0;
      hc_q    <= '0;
      sh_q    <= stream_of(tx_word);
      rx_q    <= '0;
      bits_q  <= {tx_nb, 3'b000};
      nb_q    <= tx_nb;
    end else if (busy_q) begin
      if (half_end) begin
        hc_q <= '0;
        if (!phase_q) begin
          phase_q <= 1'b1;
          rx_q    <= {rx_q[30:0], miso};
        end else begin
          phase_q <= 1'b0;
          sh_q    <= {sh_q[30:0], 1'b0};
          bits_q  <= bits_q - 6'd1;
          if (bits_q == 6'd1) busy_q <= 1'b0;
        end
      end else begin
        hc_q <= hc_q + 1'b1;
      end
    end
  end

  assign busy    = busy_q;
  assign mosi    = sh_q[31];
  assign sclk    = cpol ^ (busy_q & (phase_q ^ cpha));
  assign rx_word = place_rx(rx_q, nb_q);

  a_r3_mosi_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !bit_end) |=> $stable(mosi));
  a_r12_done_ends_word: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> !busy_q);
  a_r11_start_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |-> !rx_full);

endmodule

// File: rtl/sflash_shift_engine.sv
module sflash_shift_engine
  import sfe_pkg::*;
#(
  parameter int NCS        = 1,
  parameter int FIFO_DEPTH = 63,
  parameter int HC_W       = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [16:0]     cfg_wdata,
  output logic [16:0]     cfg_rdata,
  input  logic            tx_we,
  input  logic [1:0]      tx_sel,
  input  logic [31:0]     tx_data,
  output logic            tx_full,
  output logic            tx_empty,
  input  logic            rx_re,
  output logic [31:0]     rx_data,
  output logic            rx_valid,
  output logic            busy,
  output logic            sclk,
  output logic            mosi,
  input  logic            miso,
  output logic [NCS-1:0]  ss_n
);
  localparam int B_EN     = 0;
  localparam int B_CPOL   = 1;
  localparam int B_CPHA   = 2;
  localparam int B_DIV    = 3;
  localparam int B_SS     = 10;
  localparam int B_MCS    = 14;
  localparam int B_MSTART = 15;
  localparam int B_GO     = 16;
  localparam logic [15:0] CFG_RST = 16'(((1 << NCS) - 1) << B_SS);

  logic [15:0] cfg_q;
  logic        armed_q, part_q;

  logic        tx_push, tx_pop, rx_full, rx_empty, rx_pop;
  logic [33:0] tx_head;
  logic        start_ev, word_done, go;
  logic [31:0] rx_word;

  logic            en, cpol, cpha, mcs, mstart;
  logic [DIV_W-1:0] div;
  logic [NCS-1:0]  ss_field;
  assign en       = cfg_q[B_EN];
  assign cpol     = cfg_q[B_CPOL];
  assign cpha     = cfg_q[B_CPHA];
  assign div      = cfg_q[B_DIV +: DIV_W];
  assign ss_field = cfg_q[B_SS +: NCS];
  assign mcs      = cfg_q[B_MCS];
  assign mstart   = cfg_q[B_MSTART];

  // write acceptance: partial entries travel alone
  assign tx_push = tx_we && !tx_full && ((tx_sel == 2'd0) ? !part_q : tx_empty);
  assign tx_pop  = start_ev;
  assign rx_pop  = rx_re && !rx_empty;
  assign go      = en && !tx_empty && !rx_full && (!mstart || armed_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= CFG_RST;
      armed_q <= 1'b0;
      part_q  <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= cfg_wdata[15:0];
      if (cfg_we && cfg_wdata[B_GO]) armed_q <= 1'b1;
      else if (word_done && tx_empty && !tx_push) armed_q <= 1'b0;
      if (tx_push && tx_sel != 2'd0) part_q <= 1'b1;
      else if (tx_pop) part_q <= 1'b0;
    end
  end

  sfe_fifo #(.W(34), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .din({tx_sel, tx_data}),
    .pop(tx_pop), .dout(tx_head), .full(tx_full), .empty(tx_empty));

  sfe_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(word_done), .din(rx_word),
    .pop(rx_pop), .dout(rx_data), .full(rx_full), .empty(rx_empty));

  sfe_shifter #(.HC_W(HC_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .go(go), .rx_full(rx_full),
    .tx_word(tx_head[31:0]), .tx_nb(nbytes_of(tx_head[33:32])),
    .div(div), .cpol(cpol), .cpha(cpha), .miso(miso),
    .start_ev(start_ev), .word_done(word_done), .rx_word(rx_word),
    .busy(busy), .sclk(sclk), .mosi(mosi));

  assign rx_valid  = !rx_empty;
  assign cfg_rdata = {1'b0, cfg_q};
  assign ss_n      = (mcs || busy) ? ss_field : '1;

  a_r9_hold_until_start: assert property (@(posedge clk) disable iff (!rst_n)
    (mstart && !armed_q) |-> !tx_pop);
  a_r12_word_reaches_rx: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> rx_valid);

endmodule

// File: tb/sflash_shift_engine_tb_top.sv
module sflash_shift_engine_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [16:0] cfg_wdata = '0;
  logic [16:0] cfg_rdata;
  logic        tx_we = 1'b0;
  logic [1:0]  tx_sel = '0;
  logic [31:0] tx_data = '0;
  logic        tx_full, tx_empty, rx_valid, busy, sclk, mosi, miso;
  logic        rx_re = 1'b0;
  logic [31:0] rx_data;
  logic [0:0]  ss_n;

  sflash_shift_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tx_we(tx_we), .tx_sel(tx_sel), .tx_data(tx_data),
    .tx_full(tx_full), .tx_empty(tx_empty), .rx_re(rx_re), .rx_data(rx_data),
    .rx_valid(rx_valid), .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso),
    .ss_n(ss_n));

  always #(CLK_PERIOD/2) clk = ~clk;
  assign miso = ~mosi;   // inverted loopback slave

  int checks = 0;
  int errors = 0;
  logic [7:0]  exp_bytes[$];
  logic [31:0] exp_rx[$];
  logic cur_cpol = 1'b0, cur_cpha = 1'b0;
  int   cur_div = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: collect mosi bits on the capture edge
  int         bitcnt = 0;
  logic [7:0] shreg = '0;
  longint     last_t = 0;
  always @(sclk) begin
    if (rst_n && ss_n[0] === 1'b0 && sclk === (cur_cpha ? cur_cpol : ~cur_cpol)) begin
      if (bitcnt % 8 != 0)
        check(($time - last_t) == longint'((2 << cur_div) * CLK_PERIOD), "R2 bit spacing",
              32'($time - last_t), 32'((2 << cur_div) * CLK_PERIOD));
      last_t = $time;
      shreg = {shreg[6:0], mosi};
      bitcnt++;
      if (bitcnt % 8 == 0) begin
        if (exp_bytes.size() == 0) check(1'b0, "R7 unexpected byte", {24'd0, shreg}, 32'd0);
        else begin
          logic [7:0] e;
          e = exp_bytes.pop_front();
          check(shreg == e, "R4 R5 byte on mosi", {24'd0, shreg}, {24'd0, e});
        end
      end
    end
  end

  function automatic logic [16:0] cfg_val(bit en, bit cpol, bit cpha, int div, bit ss,
                                          bit mcs, bit mst, bit start);
    logic [16:0] v;
    v = '0;
    v[0] = en; v[1] = cpol; v[2] = cpha; v[5:3] = 3'(div);
    v[10] = ss; v[14] = mcs; v[15] = mst; v[16] = start;
    return v;
  endfunction

  task automatic cfg_write(input logic [16:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    cur_cpol = v[1]; cur_cpha = v[2]; cur_div = int'(v[5:3]);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input int sel, input logic [31:0] d, input bit accept);
    int n;
    logic [31:0] w;
    n = (sel == 0) ? 4 : sel;
    if (accept) begin
      w = '0;
      for (int k = 0; k < n; k++) begin
        exp_bytes.push_back(d[8*k +: 8]);
        w[8*(4-n+k) +: 8] = ~d[8*k +: 8];
      end
      exp_rx.push_back(w);
    end
    @(negedge clk);
    tx_we = 1'b1; tx_sel = 2'(sel); tx_data = d;
    @(negedge clk);
    tx_we = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(tx_empty && !busy));
    repeat (2) @(negedge clk);
  endtask

  task automatic drain_rx(input int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] e;
      while (!rx_valid) @(negedge clk);
      e = (exp_rx.size() != 0) ? exp_rx.pop_front() : 32'hx;
      check(rx_data === e, "R6 receive word", rx_data, e);
      rx_re = 1'b1;
      @(negedge clk);
      rx_re = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(sclk == 1'b0, "R1 sclk", 32'(sclk), 0);
    check(ss_n == 1'b1, "R1 ss_n", 32'(ss_n), 1);
    check(busy == 1'b0, "R1 busy", 32'(busy), 0);
    check(tx_empty == 1'b1, "R1 tx_empty", 32'(tx_empty), 1);
    check(rx_valid == 1'b0, "R1 rx_valid", 32'(rx_valid), 0);

    // R8 R10 auto start, full words, mode 0
    cfg_write(cfg_val(1, 0, 0, 0, 0, 0, 0, 0));
    send(0, 32'hA55A_3CC3, 1);
    @(negedge clk);
    check(busy == 1'b1, "R8 auto start", 32'(busy), 1);
    check(ss_n == 1'b0, "R10 select during word", 32'(ss_n), 0);
    send(0, 32'h0123_4567, 1);
    send(0, 32'hF00D_8001, 1);
    wait_idle();
    check(ss_n == 1'b1, "R10 select released", 32'(ss_n), 1);
    drain_rx(3);
    check(rx_valid == 1'b0, "R12 one word per entry", 32'(rx_valid), 0);

    // R5 partial entries
    send(1, 32'hDEAD_BE81, 1); wait_idle();
    send(2, 32'h1234_5678, 1); wait_idle();
    send(3, 32'h9ABC_DEF0, 1); wait_idle();
    drain_rx(3);
    check(rx_valid == 1'b0, "R12 partial one word each", 32'(rx_valid), 0);

    // R2 R3 other modes and divisors
    cfg_write(cfg_val(1, 1, 1, 2, 0, 0, 0, 0));
    @(negedge clk);
    check(sclk == 1'b1, "R3 idle level high", 32'(sclk), 1);
    send(0, 32'h5AC3_0FE1, 1);
    send(2, 32'h0000_B6D9, 1);
    wait_idle();
    drain_rx(2);
    cfg_write(cfg_val(1, 1, 0, 1, 0, 0, 0, 0));
    send(0, 32'h7E81_24DB, 1);
    wait_idle();
    drain_rx(1);

    // R9 R7 manual start, partial then dropped full
    cfg_write(cfg_val(1, 0, 0, 0, 0, 0, 1, 0));
    send(2, 32'hFFFF_C3E7, 1);
    send(0, 32'h1111_1111, 0);
    repeat (20) @(negedge clk);
    check(busy == 1'b0 && tx_empty == 1'b0, "R9 waits for start", {busy, tx_empty}, 32'b00);
    cfg_write(cfg_val(1, 0, 0, 0, 0, 0, 1, 1));
    wait_idle();
    drain_rx(1);
    check(rx_valid == 1'b0, "R7 dropped full word", 32'(rx_valid), 0);
    // full then dropped partial; start flag must have cleared
    send(0, 32'h0F1E_2D3C, 1);
    send(3, 32'h00AB_CDEF, 0);
    repeat (20) @(negedge clk);
    check(busy == 1'b0 && tx_empty == 1'b0, "R9 start pulse consumed", {busy, tx_empty}, 32'b00);
    cfg_write(cfg_val(1, 0, 0, 0, 0, 0, 1, 1));
    wait_idle();
    drain_rx(1);
    check(rx_valid == 1'b0, "R7 dropped partial word", 32'(rx_valid), 0);

    // R10 manual select
    cfg_write(cfg_val(1, 0, 0, 0, 0, 1, 0, 0));
    @(negedge clk);
    check(ss_n == 1'b0, "R10 manual select idle", 32'(ss_n), 0);
    send(0, 32'hC001_D00D, 1);
    wait_idle();
    check(ss_n == 1'b0, "R10 manual select held", 32'(ss_n), 0);
    drain_rx(1);
    cfg_write(cfg_val(1, 0, 0, 0, 1, 1, 0, 0));
    @(negedge clk);
    check(ss_n == 1'b1, "R10 manual deselect", 32'(ss_n), 1);

    // R8 disabled engine, then R11 queue limits
    cfg_write(cfg_val(0, 0, 0, 0, 0, 0, 0, 0));
    send(0, 32'h8000_0001, 1);
    repeat (30) @(negedge clk);
    check(busy == 1'b0 && tx_empty == 1'b0, "R8 disabled holds", {busy, tx_empty}, 32'b00);
    for (int i = 1; i < 63; i++) send(0, 32'h1000_0000 + 32'(i * 32'h0101_0101), 1);
    check(tx_full == 1'b1, "R11 tx full at 63", 32'(tx_full), 1);
    send(0, 32'hBAD0_BAD0, 0);
    cfg_write(cfg_val(1, 0, 0, 0, 0, 0, 0, 0));
    wait_idle();
    send(0, 32'h3355_77AA, 1);
    repeat (100) @(negedge clk);
    check(busy == 1'b0 && tx_empty == 1'b0, "R11 waits for rx room", {busy, tx_empty}, 32'b00);
    drain_rx(64);
    check(rx_valid == 1'b0, "R12 rx count matches", 32'(rx_valid), 0);
    check(exp_bytes.size() == 0, "R4 all bytes seen", 32'(exp_bytes.size()), 0);
    finish_run();
  end

endmodule